// File: doc/BRIEF.md
# Serial-Programmed Dual Converter Register Controller

This block is the digital front end of a two-channel 8-bit converter. A host writes 16-bit command words over a three-wire link: an active-low select, a serial clock and a data line, with data sampled on rising clock edges. The low 13 bits of each word form five independent control bits and a data byte. Each channel has an input (staging) register, an output register that drives the converter code, and a power-down flag. Because the control bits are not decoded as opcodes, any mix of channel addressing, power state and output update can be requested in one word.

An output update copies both staging registers into both output registers at once. It happens either when the select line rises or, if armed, on a later falling edge of an active-low load strobe. A parameter builds a variant without the strobe, in which every update happens when select rises. All four pins are brought into the system clock domain through synchronizers, and their edges are detected there. The system clock must run at least four times faster than the serial clock.

Top module: `sdac_front`

## Requirements
- R1: Each word is taken MSB first on synchronized serial-clock rising edges while select is low. In arrival order the bits are three spare bits, then PD, UPD, DEFER, B_SEL, A_SEL, then data bits 7 down to 0. Word bit 12 is PD, bit 11 is UPD, bit 10 is DEFER, bit 9 is B_SEL, bit 8 is A_SEL and bits 7:0 are the data.
- R2: A command acts only after select rises. While select is low the outputs keep their values, so a word may be sent as two bytes with a pause between them.
- R3: A_SEL=1 writes the data byte into channel A's staging register and B_SEL=1 into channel B's. With both set, both registers take the byte. With both clear, no staging register changes.
- R4: UPD=1 copies both staging registers into both output registers, whatever A_SEL and B_SEL are. UPD=0 leaves the output registers unchanged.
- R5: With UPD=1 and DEFER=0, the copy happens when select rises and uses the staging values written by the same command.
- R6: With UPD=1 and DEFER=1, the copy is held back until the first falling edge of the load strobe after the command.
- R7: PD sets each addressed channel's power-down flag to its own value, and unaddressed flags keep theirs. A held-back copy still takes effect while a channel is powered down.
- R8: After reset, all staging registers, output registers, power-down flags and the held-back request are zero.
- R9: With HAS_STROBE=0, DEFER is ignored, every UPD=1 copy happens when select rises, and strobe edges have no effect.
- R10: A word framed by fewer than 16 serial clocks is discarded. If more than 16 arrive, the last 16 bits are used.
- R11: One strobe falling edge consumes the held-back request, and later edges copy nothing. A command with UPD=0 does not cancel the request. A new UPD=1, DEFER=1 command arms it again.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock, at least 4x the serial clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| sel_n | input | 1 | Active-low frame select |
| sck | input | 1 | Serial clock, data taken on rising edge |
| sdi | input | 1 | Serial data in |
| load_n | input | 1 | Active-low load strobe, falling edge applies a held-back copy |
| chan_a_code | output | 8 | Channel A output register |
| chan_b_code | output | 8 | Channel B output register |
| chan_a_off | output | 1 | Channel A power-down flag |
| chan_b_off | output | 1 | Channel B power-down flag |

## Verification
The bench builds two copies of the block on shared pins, one with HAS_STROBE=1 and one with HAS_STROBE=0. Every strobe pulse therefore also checks that the strobe has no effect in the variant without it. It sweeps all 32 settings of the five control bits, each with a distinct data byte and spare-bit pattern, and pulses the strobe after every command. This covers every mix of addressing, power state, immediate copy and held-back copy against an arithmetic model. Directed words add split transfers, short and long frames, and the arm, keep and consume sequence of the held-back request.

// File: rtl/sdac_pkg.sv
package sdac_pkg;
  localparam int unsigned CODE_W = 8;
  localparam int unsigned NUM_CH = 2;
  localparam int unsigned WORD_W = 16;

  // tail of the serial word, first-arriving field at the top
  typedef struct packed {
    logic              pwr_dn;
    logic              upd_en;
    logic              upd_defer;
    logic              sel_b;
    logic              sel_a;
    logic [CODE_W-1:0] code;
  } sdac_cmd_t;
endpackage

// File: rtl/sdac_sync.sv
module sdac_sync #(
  parameter int unsigned W      = 1,
  parameter int unsigned STAGES = 2,
  parameter logic [W-1:0] RST_VAL = '0
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic [W-1:0] d_async,
  output logic [W-1:0] q
);
  logic [W-1:0] stg_q [STAGES];

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      for (int i = 0; i < STAGES; i++) stg_q[i] <= RST_VAL;
    end else begin
      stg_q[0] <= d_async;
      for (int i = 1; i < STAGES; i++) stg_q[i] <= stg_q[i-1];
    end
  end

  assign q = stg_q[STAGES-1];
endmodule

// File: rtl/sdac_shifter.sv
module sdac_shifter
  import sdac_pkg::*;
#(
  parameter int unsigned FRAME_W = WORD_W
) (
  input  logic      clk,
  input  logic      rst_n,
  input  logic      sel_s,
  input  logic      sck_s,
  input  logic      sdi_s,
  output sdac_cmd_t cmd,
  output logic      cmd_exec
);
  localparam int unsigned KEEP_W = $bits(sdac_cmd_t);
  localparam int unsigned CNT_W  = $clog2(FRAME_W + 1);
  localparam logic [CNT_W-1:0] FULL = CNT_W'(FRAME_W);

  logic              sel_q, sck_q;
  logic [KEEP_W-1:0] sh_q, sh_d;
  logic [CNT_W-1:0]  cnt_q, cnt_d;
  logic              sck_rise, sel_rise;

  assign sck_rise = sck_s & ~sck_q & ~sel_s;
  assign sel_rise = sel_s & ~sel_q;

  always_comb begin
    sh_d  = sh_q;
    cnt_d = cnt_q;
    if (sel_s) begin
      cnt_d = '0;
    end else if (sck_rise) begin
      sh_d = {sh_q[KEEP_W-2:0], sdi_s};
      if (cnt_q != FULL) cnt_d = cnt_q + 1'b1;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      sel_q <= 1'b1;
      sck_q <= 1'b0;
      sh_q  <= '0;
      cnt_q <= '0;
    end else begin
      sel_q <= sel_s;
      sck_q <= sck_s;
      if (sck_rise) sh_q <= sh_d;
      cnt_q <= cnt_d;
    end
  end

  assign cmd      = sdac_cmd_t'(sh_q);
  assign cmd_exec = sel_rise & (cnt_q == FULL);
endmodule

// File: rtl/sdac_regs.sv
module sdac_regs
  import sdac_pkg::*;
#(
  parameter int unsigned HAS_STROBE = 1
) (
  input  logic                           clk,
  input  logic                           rst_n,
  input  sdac_cmd_t                      cmd,
  input  logic                           cmd_exec,
  input  logic                           ldn_s,
  output logic [NUM_CH-1:0][CODE_W-1:0]  code_o,
  output logic [NUM_CH-1:0]              off_o,
  output logic                           armed,
  output logic                           ld_fire
);
  localparam logic DEFER_OK = (HAS_STROBE != 0);

  logic              ld_fall;
  logic              armed_q, armed_d;
  logic              defer_req, now_upd, copy_all;
  logic [NUM_CH-1:0] hit;

  generate
    if (HAS_STROBE != 0) begin : g_strobe
      logic ldn_q;
      always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) ldn_q <= 1'b1;
        else        ldn_q <= ldn_s;
      end
      assign ld_fall = ldn_q & ~ldn_s;
    end else begin : g_nostrobe
      assign ld_fall = 1'b0;
    end
  endgenerate

  assign hit       = {cmd.sel_b, cmd.sel_a};
  assign defer_req = cmd_exec & cmd.upd_en & cmd.upd_defer & DEFER_OK;
  assign now_upd   = cmd_exec & cmd.upd_en & ~defer_req;
  assign ld_fire   = ld_fall & armed_q;
  assign copy_all  = now_upd | ld_fire;

  always_comb begin
    armed_d = armed_q;
    if (defer_req)    armed_d = 1'b1;
    else if (ld_fire) armed_d = 1'b0;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) armed_q <= 1'b0;
    else        armed_q <= armed_d;
  end

  assign armed = armed_q;

  for (genvar ch = 0; ch < NUM_CH; ch++) begin : g_ch
    logic [CODE_W-1:0] in_q, in_d, out_q, out_d;
    logic              off_q, off_d;
    logic              wr;

    assign wr = cmd_exec & hit[ch];

    always_comb begin
      in_d  = wr ? cmd.code : in_q;
      out_d = copy_all ? in_d : out_q;
      off_d = wr ? cmd.pwr_dn : off_q;
    end

    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
        in_q  <= '0;
        out_q <= '0;
        off_q <= 1'b0;
      end else begin
        if (wr)       in_q  <= in_d;
        if (copy_all) out_q <= out_d;
        if (wr)       off_q <= off_d;
      end
    end

    assign code_o[ch] = out_q;
    assign off_o[ch]  = off_q;
  end
endmodule

// File: rtl/sdac_front.sv
module sdac_front
  import sdac_pkg::*;
#(
  parameter int unsigned HAS_STROBE  = 1,
  parameter int unsigned SYNC_STAGES = 2
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              sel_n,
  input  logic              sck,
  input  logic              sdi,
  input  logic              load_n,
  output logic [CODE_W-1:0] chan_a_code,
  output logic [CODE_W-1:0] chan_b_code,
  output logic              chan_a_off,
  output logic              chan_b_off
);
  logic [3:0]                    pins_s;
  logic                          sel_s, sck_s, sdi_s, ldn_s;
  sdac_cmd_t                     cmd;
  logic                          cmd_exec;
  logic                          armed, ld_fire;
  logic [NUM_CH-1:0][CODE_W-1:0] code_all;
  logic [NUM_CH-1:0]             off_all;

  // select and strobe idle high
  sdac_sync #(.W(4), .STAGES(SYNC_STAGES), .RST_VAL(4'b1001)) u_sync (
    .clk     (clk),
    .rst_n   (rst_n),
    .d_async ({sel_n, sck, sdi, load_n}),
    .q       (pins_s)
  );

  assign {sel_s, sck_s, sdi_s, ldn_s} = pins_s;

  sdac_shifter #(.FRAME_W(WORD_W)) u_shift (
    .clk      (clk),
    .rst_n    (rst_n),
    .sel_s    (sel_s),
    .sck_s    (sck_s),
    .sdi_s    (sdi_s),
    .cmd      (cmd),
    .cmd_exec (cmd_exec)
  );

  sdac_regs #(.HAS_STROBE(HAS_STROBE)) u_regs (
    .clk      (clk),
    .rst_n    (rst_n),
    .cmd      (cmd),
    .cmd_exec (cmd_exec),
    .ldn_s    (ldn_s),
    .code_o   (code_all),
    .off_o    (off_all),
    .armed    (armed),
    .ld_fire  (ld_fire)
  );

  assign chan_a_code = code_all[0];
  assign chan_b_code = code_all[1];
  assign chan_a_off  = off_all[0];
  assign chan_b_off  = off_all[1];
endmodule

// File: rtl/sdac_chk.sv
module sdac_chk #(
  parameter int unsigned HAS_STROBE = 1
) (
  input logic       clk,
  input logic       rst_n,
  input logic       sel_s,
  input logic       cmd_exec,
  input logic       ld_fire,
  input logic       armed,
  input logic [7:0] chan_a_code,
  input logic [7:0] chan_b_code,
  input logic       chan_a_off,
  input logic       chan_b_off
);
  // R2: nothing moves while the frame is open, except a strobe-driven copy
  p_quiet_open_frame_r2: assert property (@(posedge clk) disable iff (!rst_n)
    (!sel_s && !ld_fire) |=> $stable({chan_a_code, chan_b_code, chan_a_off, chan_b_off}));

  // R4: output codes move only on a command or a strobe copy
  p_codes_gated_r4: assert property (@(posedge clk) disable iff (!rst_n)
    !(cmd_exec || ld_fire) |=> $stable({chan_a_code, chan_b_code}));

  // R7: power flags move only on a command
  p_off_gated_r7: assert property (@(posedge clk) disable iff (!rst_n)
    !cmd_exec |=> $stable({chan_a_off, chan_b_off}));

  // R11: a strobe copy consumes the request
  p_fire_consumes_r11: assert property (@(posedge clk) disable iff (!rst_n)
    (ld_fire && !cmd_exec) |=> !armed);

  // R9: without the strobe no request is ever held
  p_no_arm_r9: assert property (@(posedge clk) disable iff (!rst_n)
    (HAS_STROBE == 0) |-> !armed);
endmodule

bind sdac_front sdac_chk #(.HAS_STROBE(HAS_STROBE)) u_chk (
  .clk         (clk),
  .rst_n       (rst_n),
  .sel_s       (sel_s),
  .cmd_exec    (cmd_exec),
  .ld_fire     (ld_fire),
  .armed       (armed),
  .chan_a_code (chan_a_code),
  .chan_b_code (chan_b_code),
  .chan_a_off  (chan_a_off),
  .chan_b_off  (chan_b_off)
);

// File: tb/test_sdac_front.sv
module test_sdac_front;
  logic clk = 1'b0;
  logic rst_n, sel_n, sck, sdi, load_n;
  logic [7:0] ya, yb, za, zb;
  logic       yoa, yob, zoa, zob;
  int total = 0;
  int bad   = 0;

  always #10 clk = ~clk;

  sdac_front #(.HAS_STROBE(1)) i_sdac_front (
    .clk(clk), .rst_n(rst_n), .sel_n(sel_n), .sck(sck), .sdi(sdi), .load_n(load_n),
    .chan_a_code(ya), .chan_b_code(yb), .chan_a_off(yoa), .chan_b_off(yob));

  sdac_front #(.HAS_STROBE(0)) i_sdac_front_nostb (
    .clk(clk), .rst_n(rst_n), .sel_n(sel_n), .sck(sck), .sdi(sdi), .load_n(load_n),
    .chan_a_code(za), .chan_b_code(zb), .chan_a_off(zoa), .chan_b_off(zob));

  // model, index 0 = with strobe, 1 = without
  logic [7:0] m_in  [2][2];
  logic [7:0] m_out [2][2];
  logic       m_off [2][2];
  logic       m_arm [2];

  function automatic logic [15:0] mk(input logic [2:0] ub, input logic [4:0] ctl,
                                     input logic [7:0] d);
    return {ub, ctl, d};
  endfunction

  task automatic tick(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic model_cmd(input logic [15:0] w);
    for (int v = 0; v < 2; v++) begin
      if (w[8]) begin m_in[v][0] = w[7:0]; m_off[v][0] = w[12]; end
      if (w[9]) begin m_in[v][1] = w[7:0]; m_off[v][1] = w[12]; end
      if (w[11]) begin
        if (w[10] && v == 0) m_arm[v] = 1'b1;
        else begin m_out[v][0] = m_in[v][0]; m_out[v][1] = m_in[v][1]; end
      end
    end
  endtask

  task automatic shift_bits(input logic [31:0] w, input int n);
    for (int i = n - 1; i >= 0; i--) begin
      sdi = w[i];
      tick(3);
      sck = 1'b1;
      tick(3);
      sck = 1'b0;
    end
  endtask

  task automatic send(input logic [31:0] w, input int n);
    sel_n = 1'b0;
    tick(3);
    shift_bits(w, n);
    tick(3);
    sel_n = 1'b1;
    tick(8);
    if (n >= 16) model_cmd(w[15:0]);
  endtask

  task automatic strobe();
    load_n = 1'b0;
    tick(6);
    load_n = 1'b1;
    tick(6);
    if (m_arm[0]) begin
      m_out[0][0] = m_in[0][0];
      m_out[0][1] = m_in[0][1];
      m_arm[0] = 1'b0;
    end
  endtask

  task automatic check_all(input string tag);
    logic [17:0] act0, exp0, act1, exp1;
    act0 = {ya, yb, yoa, yob};
    exp0 = {m_out[0][0], m_out[0][1], m_off[0][0], m_off[0][1]};
    act1 = {za, zb, zoa, zob};
    exp1 = {m_out[1][0], m_out[1][1], m_off[1][0], m_off[1][1]};
    total++;
    if (act0 !== exp0) begin
      bad++;
      $display("FAIL %s strobe variant act=%h exp=%h", tag, act0, exp0);
    end
    total++;
    if (act1 !== exp1) begin
      bad++;
      $display("FAIL %s no-strobe variant act=%h exp=%h", tag, act1, exp1);
    end
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    bad++;
    total++;
    $display("FAIL watchdog expired");
    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    for (int v = 0; v < 2; v++) begin
      m_arm[v] = 1'b0;
      for (int c = 0; c < 2; c++) begin
        m_in[v][c] = '0; m_out[v][c] = '0; m_off[v][c] = 1'b0;
      end
    end
    rst_n = 1'b0; sel_n = 1'b1; sck = 1'b0; sdi = 1'b0; load_n = 1'b1;
    tick(5);
    rst_n = 1'b1;
    tick(5);
    check_all("R8 reset state");

    // R1 R3 R4 R5 R6 R7 R9: every control combination, then a strobe
    for (int k = 0; k < 32; k++) begin
      send({16'h0, mk(3'(k) ^ 3'b101, 5'(k), 8'(k * 37 + 11))}, 16);
      check_all("R1 R3 R4 R5 R7 command sweep");
      strobe();
      check_all("R6 R9 R11 strobe after sweep command");
    end

    // R2: split transfer, outputs still during the pause
    sel_n = 1'b0;
    tick(3);
    shift_bits({16'h0, mk(3'b000, 5'b01011, 8'hC3)}, 16 - 8);
    tick(3);
    shift_bits({24'h0, mk(3'b000, 5'b01011, 8'hC3) >> 8}, 8);
    tick(40);
    check_all("R2 outputs held mid-frame");
    sel_n = 1'b0;
    tick(3);
    sel_n = 1'b1;
    tick(8);
    // frame was first 8 bits of data then 8 bits of control: rebuild properly
    // (the above wrote the halves in the wrong order on purpose: 16 bits total,
    // last 16 shifted are data-byte then control-byte)
    model_cmd({8'hC3, 3'b000, 5'b01011});
    check_all("R2 R10 swapped halves executed as shifted");

    sel_n = 1'b0;
    tick(3);
    shift_bits({24'h0, 8'(mk(3'b111, 5'b01011, 8'h96) >> 8)}, 8);
    tick(50);
    check_all("R2 outputs held during pause");
    shift_bits({24'h0, 8'h96}, 8);
    tick(3);
    sel_n = 1'b1;
    tick(8);
    model_cmd(mk(3'b111, 5'b01011, 8'h96));
    check_all("R2 segmented word executed");

    // R10: short frame discarded, long frame keeps last 16 bits
    send({16'h0, mk(3'b000, 5'b01011, 8'h21)} >> 4, 12);
    check_all("R10 short frame discarded");
    send({12'h0, 4'hF, mk(3'b010, 5'b01010, 8'h3C)}, 20);
    check_all("R10 long frame last 16 bits");

    // R11: arm, overwrite staging with no update, fire, then fire again
    send({16'h0, mk(3'b000, 5'b01101, 8'h5A)}, 16);
    check_all("R11 armed, outputs waiting");
    send({16'h0, mk(3'b000, 5'b00001, 8'h33)}, 16);
    check_all("R11 no-update command keeps request");
    strobe();
    check_all("R11 strobe applies newest staging");
    send({16'h0, mk(3'b000, 5'b00011, 8'h44)}, 16);
    strobe();
    check_all("R11 second strobe copies nothing");
    send({16'h0, mk(3'b000, 5'b01110, 8'h0F)}, 16);
    send({16'h0, mk(3'b000, 5'b01101, 8'hE1)}, 16);
    strobe();
    check_all("R11 re-armed request applied");

    // R7: held-back copy while powered down
    send({16'h0, mk(3'b000, 5'b11111, 8'h77)}, 16);
    check_all("R7 both powered down, copy waiting");
    strobe();
    check_all("R7 copy applied while powered down");

    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule